// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a synchronous host and an asynchronous 1M x 16 DRAM with a multiplexed address bus. The host offers one word request at a time: a 20-bit word address, 16-bit write data, two byte enables and a write flag, under a valid/ready handshake. The controller splits the address into a row half and a column half. It sends the row half on the shared address pins when the row strobe falls, and the column half when the column strobes fall. Writes use the early-write form. Reads open the output enable and capture the returned lanes, which come back to the host with a one-cycle valid pulse.

A row stays open after an access. A later request to the same row skips activation and only pulses the column strobes again. A request to another row closes the open one first. A row that has reached its low-time budget is closed either on its next request or on its own when no request arrives. All timings are whole clock counts given by parameters. The two column strobes act as byte selects: the low strobe carries data bits 7:0 and the high strobe carries data bits 15:8.

Top module: `fpdram_ctrl`

## Requirements
- R1: While reset is applied, RAS, both CAS strobes, WE and OE are high, the data lanes are not driven, no read data is flagged valid, and the request port reports ready.
- R2: The row is address bits 19:10, placed on the address pins when RAS falls. The column is bits 9:0, placed on the pins when CAS falls. CAS only falls while RAS is low, and requests reach the DRAM in the order they were accepted.
- R3: The low CAS strobe falls exactly when enable bit 0 is set and the high one exactly when bit 1 is set. Read data in a lane whose enable is clear returns as zero.
- R4: For a write, WE is low at least one cycle before CAS falls and the controller drives the write data on the lanes, with OE held high.
- R5: For a read, WE is high, OE is low and the lanes are not driven while CAS is low.
- R6: Each CAS low pulse lasts exactly T_CAS cycles.
- R7: The first CAS fall of an opened row comes exactly T_RCD+1 cycles after RAS falls.
- R8: Between two accesses in one open row, RAS stays low and CAS stays high for at least T_CP+1 cycles.
- R9: RAS stays high for at least T_RP cycles before each fall.
- R10: RAS is never low for more than T_RAS_MAX cycles. A row whose budget cannot fit one more access is closed, even while no request is pending.
- R11: Counting from the clock edge that accepts a read, read data is valid after T_CAS+1 cycles for an open-row hit, after T_RCD+T_CAS+1 cycles from a closed row, and after T_RP+T_RCD+T_CAS+1 cycles when an open row must be closed first.
- R12: Each read returns the word last written to that address, merged per byte lane, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = lanes 7:0 |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Read data |
| dram_addr | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| lcas_n | output | 1 | Column strobe for lanes 7:0 |
| ucas_n | output | 1 | Column strobe for lanes 15:8 |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | 16 | Data driven to the DRAM |
| dq_oe | output | 1 | Enables the data lane drivers |
| dq_in | input | 16 | Data returned by the DRAM |

## Verification
The cycle that accepts a request is known at the negative edge before it, because ready is steady there. At that moment the bench decides whether the request is a hit, a closed-row access or a row change. It uses only the row and the RAS-low count it has watched on the pins, and from these it fixes the cycle in which read data is due, per R11. The pin checks are made one time unit after each rising edge. Strobe edges are compared against run-length counters kept from the pins alone, so each interval is checked at the sample where the edge first shows.

// File: rtl/fpdram_pkg.sv
`timescale 1ns/1ps
package fpdram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,  // row closed, precharge satisfied
        ST_PRE  = 3'd1,  // RAS high, precharge counting
        ST_RCD  = 3'd2,  // RAS low, row address held
        ST_COL  = 3'd3,  // column address and WE set up, CAS high
        ST_CAS  = 3'd4,  // CAS low
        ST_OPEN = 3'd5   // row open, CAS high
    } fp_state_e;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/fpdram_ras_timer.sv
`timescale 1ns/1ps
module fpdram_ras_timer #(
    parameter int unsigned LIMIT = 10000,
    localparam int RC_W = $clog2(LIMIT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ras_n_q,
    output logic [RC_W-1:0] low_cycles
);
    // Number of completed RAS-low cycles before the current one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_cycles <= '0;
        else if (ras_n_q)
            low_cycles <= '0;
        else if (low_cycles != RC_W'(LIMIT))
            low_cycles <= low_cycles + 1'b1;
    end
endmodule

// File: rtl/fpdram_row_match.sv
`timescale 1ns/1ps
module fpdram_row_match #(
    parameter int ROW_W = 10,
    parameter int RC_W = 14,
    parameter int unsigned BUDGET = 0
) (
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    input  logic [RC_W-1:0]  low_cycles,
    output logic             same_row,
    output logic             within_budget
);
    assign same_row      = (open_row == req_row);
    assign within_budget = (32'(low_cycles) <= BUDGET);
endmodule

// File: rtl/fpdram_ctrl.sv
`timescale 1ns/1ps
module fpdram_ctrl
    import fpdram_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DQ_W = 16,
    parameter int unsigned T_RCD = 2,
    parameter int unsigned T_CAS = 2,
    parameter int unsigned T_CP = 2,
    parameter int unsigned T_RP = 3,
    parameter int unsigned T_RAS_MAX = 10000,
    localparam int COL_W = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DQ_W-1:0]   req_wdata,
    input  logic [1:0]        req_be,
    output logic              rd_valid,
    output logic [DQ_W-1:0]   rd_data,
    output logic [COL_W-1:0]  dram_addr,
    output logic              ras_n,
    output logic              lcas_n,
    output logic              ucas_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [DQ_W-1:0]   dq_out,
    output logic              dq_oe,
    input  logic [DQ_W-1:0]   dq_in
);
    localparam int ROW_W = ADDR_W - COL_W;
    localparam int LANE_W = DQ_W / 2;
    localparam int unsigned TMAX = max4(T_RCD, T_CAS, T_CP, T_RP);
    localparam int CW = $clog2(TMAX + 1);
    localparam int RC_W = $clog2(T_RAS_MAX + 1);
    localparam int unsigned CP_WAIT = T_CP - 1;
    // Last RAS-low count at which one more page access still fits.
    localparam int unsigned BUDGET = T_RAS_MAX - T_CAS - 3;

    typedef struct packed {
        fp_state_e         st;
        logic [CW-1:0]     cnt;
        logic              pend;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   wdata;
        logic [1:0]        be;
        logic [ROW_W-1:0]  row;
        logic              ras_n;
        logic              lcas_n;
        logic              ucas_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
        logic [COL_W-1:0]  ma;
        logic [DQ_W-1:0]   dq_out;
        logic              rvalid;
        logic [DQ_W-1:0]   rdata;
    } regs_t;

    regs_t q, d;
    logic [RC_W-1:0] low_cycles;
    logic same_row, within_budget, accept;

    fpdram_ras_timer #(.LIMIT(T_RAS_MAX)) u_ras_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .ras_n_q    (q.ras_n),
        .low_cycles (low_cycles)
    );

    fpdram_row_match #(.ROW_W(ROW_W), .RC_W(RC_W), .BUDGET(BUDGET)) u_row_match (
        .open_row      (q.row),
        .req_row       (req_addr[ADDR_W-1:COL_W]),
        .low_cycles    (low_cycles),
        .same_row      (same_row),
        .within_budget (within_budget)
    );

    assign req_ready = (q.st == ST_IDLE) ||
                       (q.st == ST_OPEN && q.cnt >= CW'(CP_WAIT));
    assign accept = req_valid && req_ready;

    function automatic regs_t take_req(regs_t r, logic we, logic [ADDR_W-1:0] a,
                                       logic [DQ_W-1:0] wd, logic [1:0] be);
        regs_t n = r;
        n.we = we;
        n.addr = a;
        n.wdata = wd;
        n.be = be;
        return n;
    endfunction

    function automatic regs_t start_col(regs_t r);
        regs_t n = r;
        n.st = ST_COL;
        n.cnt = '0;
        n.ma = r.addr[COL_W-1:0];
        n.we_n = ~r.we;
        n.oe_n = r.we;
        n.dq_oe = r.we;
        n.dq_out = r.wdata;
        return n;
    endfunction

    function automatic regs_t start_row(regs_t r);
        regs_t n = r;
        n.st = ST_RCD;
        n.cnt = '0;
        n.pend = 1'b0;
        n.ras_n = 1'b0;
        n.row = r.addr[ADDR_W-1:COL_W];
        n.ma = COL_W'(r.addr[ADDR_W-1:COL_W]);
        return n;
    endfunction

    always_comb begin
        d = q;
        d.rvalid = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (accept)
                    d = start_row(take_req(q, req_we, req_addr, req_wdata, req_be));
            end
            ST_PRE: begin
                if (q.cnt == CW'(T_RP - 1)) begin
                    if (q.pend) begin
                        d = start_row(q);
                    end else begin
                        d.st = ST_IDLE;
                        d.cnt = '0;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_RCD: begin
                if (q.cnt == CW'(T_RCD - 1))
                    d = start_col(q);
                else
                    d.cnt = q.cnt + 1'b1;
            end
            ST_COL: begin
                d.st = ST_CAS;
                d.cnt = '0;
                d.lcas_n = ~q.be[0];
                d.ucas_n = ~q.be[1];
            end
            ST_CAS: begin
                if (q.cnt == CW'(T_CAS - 1)) begin
                    d.st = ST_OPEN;
                    d.cnt = '0;
                    d.lcas_n = 1'b1;
                    d.ucas_n = 1'b1;
                    d.we_n = 1'b1;
                    d.oe_n = 1'b1;
                    d.dq_oe = 1'b0;
                    if (!q.we) begin
                        d.rvalid = 1'b1;
                        d.rdata = dq_in & {{LANE_W{q.be[1]}}, {LANE_W{q.be[0]}}};
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_OPEN: begin
                if (accept) begin
                    d = take_req(q, req_we, req_addr, req_wdata, req_be);
                    if (same_row && within_budget) begin
                        d = start_col(d);
                    end else begin
                        d.st = ST_PRE;
                        d.cnt = '0;
                        d.ras_n = 1'b1;
                        d.pend = 1'b1;
                    end
                end else if (!within_budget) begin
                    d.st = ST_PRE;
                    d.cnt = '0;
                    d.ras_n = 1'b1;
                    d.pend = 1'b0;
                end else if (q.cnt < CW'(CP_WAIT)) begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
            q.st <= ST_IDLE;
            q.ras_n <= 1'b1;
            q.lcas_n <= 1'b1;
            q.ucas_n <= 1'b1;
            q.we_n <= 1'b1;
            q.oe_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_valid  = q.rvalid;
    assign rd_data   = q.rdata;
    assign dram_addr = q.ma;
    assign ras_n     = q.ras_n;
    assign lcas_n    = q.lcas_n;
    assign ucas_n    = q.ucas_n;
    assign we_n      = q.we_n;
    assign oe_n      = q.oe_n;
    assign dq_out    = q.dq_out;
    assign dq_oe     = q.dq_oe;
endmodule

// File: rtl/fpdram_ctrl_chk.sv
`timescale 1ns/1ps
module fpdram_ctrl_chk #(
    parameter int unsigned T_CAS = 2,
    parameter int unsigned T_RP = 3,
    parameter int unsigned T_RAS_MAX = 10000
) (
    input logic clk,
    input logic rst_n,
    input logic ras_n,
    input logic lcas_n,
    input logic ucas_n,
    input logic we_n,
    input logic oe_n,
    input logic dq_oe
);
    localparam int LW = $clog2(T_RAS_MAX + 2);

    logic cas_low;
    logic [LW-1:0] cas_run, ras_run, hi_run;
    assign cas_low = !lcas_n || !ucas_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cas_run <= '0;
            ras_run <= '0;
            hi_run  <= LW'(T_RP);
        end else begin
            cas_run <= !cas_low ? '0 : (cas_run == '1 ? cas_run : cas_run + 1'b1);
            ras_run <= ras_n ? '0 : (ras_run == '1 ? ras_run : ras_run + 1'b1);
            hi_run  <= !ras_n ? '0 : (hi_run >= LW'(T_RP) ? hi_run : hi_run + 1'b1);
        end
    end

    assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cas_low |-> !ras_n);

    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_low && !$past(cas_low) && !we_n) |-> (!$past(we_n) && dq_oe && oe_n));

    assert_read_enables_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (we_n && !dq_oe));

    assert_cas_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_low && $past(cas_low)) |-> (cas_run == LW'(T_CAS)));

    assert_precharge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(ras_n)) |-> (hi_run >= LW'(T_RP)));

    assert_ras_budget_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (ras_run < LW'(T_RAS_MAX)));
endmodule

bind fpdram_ctrl fpdram_ctrl_chk #(
    .T_CAS(T_CAS), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
    .we_n(we_n), .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/fpdram_ctrl_test.sv
`timescale 1ns/1ps
module fpdram_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int T_RCD = 2, T_CAS = 2, T_CP = 2, T_RP = 3, T_RAS_MAX = 24;
    localparam int HIT_MAX = T_RAS_MAX - T_CAS - 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_we = 1'b0, req_ready;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0, rd_data, dq_out;
    logic [15:0] dq_in = '0;
    logic [1:0] req_be = 2'b11;
    logic rd_valid, ras_n, lcas_n, ucas_n, we_n, oe_n, dq_oe;
    logic [9:0] dram_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpdram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP), .T_RP(T_RP),
                  .T_RAS_MAX(T_RAS_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr), .ras_n(ras_n),
        .lcas_n(lcas_n), .ucas_n(ucas_n), .we_n(we_n), .oe_n(oe_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int tests = 0, fails = 0;
    int unsigned cyc = 0;

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    typedef struct { bit we; logic [19:0] addr; logic [1:0] be; } op_t;
    typedef struct { logic [15:0] data; int unsigned due; } rd_t;
    op_t opq[$];
    rd_t rdq[$];
    logic [15:0] shadow[int];
    logic [15:0] dmem[int];

    function automatic logic [15:0] seed_word(int key);
        return 16'(key) ^ 16'hA53C ^ {4'(key >>> 16), 12'h000};
    endfunction

    // pin-level DRAM model and timing monitor
    bit prev_ras = 1, prev_cas = 0, prev_we = 1, seen_cas = 0;
    int rl = 0, rh = 100, cl = 0, ch = 0;
    logic [9:0] mrow = '0, mcol = '0;

    always @(posedge clk) begin
        #1;
        cyc++;
        if (rst_n) begin
            bit cas_low;
            int key;
            logic [15:0] w;
            op_t op;
            rd_t r;
            cas_low = !lcas_n || !ucas_n;
            if (!ras_n && prev_ras) begin
                check(rh >= T_RP, "R9", "RAS precharge cycles", rh, T_RP);
                mrow = dram_addr;
                rl = 0;
                seen_cas = 0;
            end
            if (ras_n && !prev_ras)
                check(rl <= T_RAS_MAX, "R10", "RAS low cycles", rl, T_RAS_MAX);
            if (!ras_n) begin rl++; rh = 0; end else rh++;
            if (cas_low && !prev_cas) begin
                check(!ras_n, "R2", "CAS fall with RAS low", ras_n, 0);
                if (!seen_cas)
                    check(rl == T_RCD + 2, "R7", "RAS-to-CAS samples", rl, T_RCD + 2);
                else
                    check(ch >= T_CP + 1, "R8", "CAS high gap", ch, T_CP + 1);
                seen_cas = 1;
                mcol = dram_addr;
                if (opq.size() == 0) begin
                    check(0, "R2", "CAS without request", 1, 0);
                end else begin
                    op = opq.pop_front();
                    check({mrow, mcol} == op.addr, "R2", "row/column", {mrow, mcol}, op.addr);
                    check({!ucas_n, !lcas_n} == op.be, "R3", "lane strobes",
                          {!ucas_n, !lcas_n}, op.be);
                    key = int'({mrow, mcol});
                    if (op.we) begin
                        check(!prev_we && !we_n && dq_oe && oe_n, "R4", "early write setup",
                              {prev_we, we_n, dq_oe, oe_n}, 4'b0011);
                        w = dmem.exists(key) ? dmem[key] : seed_word(key);
                        if (!lcas_n) w[7:0] = dq_out[7:0];
                        if (!ucas_n) w[15:8] = dq_out[15:8];
                        dmem[key] = w;
                    end else begin
                        check(we_n && !oe_n && !dq_oe, "R5", "read enables",
                              {we_n, oe_n, dq_oe}, 3'b100);
                    end
                end
            end
            if (!cas_low && prev_cas)
                check(cl == T_CAS, "R6", "CAS low cycles", cl, T_CAS);
            if (cas_low) begin cl++; ch = 0; end else begin cl = 0; ch++; end
            if (rd_valid) begin
                if (rdq.size() == 0) begin
                    check(0, "R12", "unexpected read data", rd_data, 0);
                end else begin
                    r = rdq.pop_front();
                    check(rd_data == r.data, "R12", "read data", rd_data, r.data);
                    check(cyc == r.due, "R11", "read latency", cyc, r.due);
                end
            end
            if (rdq.size() > 0 && cyc > rdq[0].due) begin
                check(0, "R11", "read data missing", cyc, rdq[0].due);
                void'(rdq.pop_front());
            end
            dq_in = '0;
            if (cas_low && !oe_n) begin
                key = int'({mrow, mcol});
                w = dmem.exists(key) ? dmem[key] : seed_word(key);
                if (!lcas_n) dq_in[7:0] = w[7:0];
                if (!ucas_n) dq_in[15:8] = w[15:8];
            end
            prev_ras = ras_n;
            prev_cas = cas_low;
            prev_we = we_n;
        end
    end

    // called at a negative edge; returns at the negative edge after acceptance
    task automatic issue(bit we, logic [19:0] a, logic [15:0] dat, logic [1:0] be);
        int unsigned lat;
        logic [15:0] cur;
        rd_t r;
        req_valid = 1; req_we = we; req_addr = a; req_wdata = dat; req_be = be;
        while (!req_ready) @(negedge clk);
        if (ras_n) lat = T_RCD + 1 + T_CAS;
        else if (a[19:10] == mrow && rl <= HIT_MAX) lat = 1 + T_CAS;
        else lat = T_RP + T_RCD + 1 + T_CAS;
        opq.push_back('{we, a, be});
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : seed_word(int'(a));
        if (we) begin
            if (be[0]) cur[7:0] = dat[7:0];
            if (be[1]) cur[15:8] = dat[15:8];
            shadow[int'(a)] = cur;
        end else begin
            r.data = cur & {{8{be[1]}}, {8{be[0]}}};
            r.due = cyc + 1 + lat;
            rdq.push_back(r);
        end
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned x;
        logic [9:0] rows [3];
        rows[0] = 10'd5; rows[1] = 10'd9; rows[2] = 10'd200;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ras_n && lcas_n && ucas_n && we_n && oe_n, "R1", "strobes in reset",
              {ras_n, lcas_n, ucas_n, we_n, oe_n}, 5'b11111);
        check(!dq_oe && !rd_valid, "R1", "lanes and valid in reset", {dq_oe, rd_valid}, 0);
        check(req_ready, "R1", "ready in reset", req_ready, 1);
        rst_n = 1;
        @(negedge clk);
        // R4 write then R11 hit reads in the open row
        issue(1, {10'd5, 10'd3}, 16'hBEEF, 2'b11);
        issue(0, {10'd5, 10'd3}, 16'h0, 2'b11);
        issue(0, {10'd5, 10'd7}, 16'h0, 2'b11);
        // R3 byte lanes
        issue(1, {10'd5, 10'd3}, 16'h1234, 2'b10);
        issue(0, {10'd5, 10'd3}, 16'h0, 2'b01);
        issue(0, {10'd5, 10'd3}, 16'h0, 2'b10);
        issue(0, {10'd5, 10'd3}, 16'h0, 2'b11);
        // R9 row change
        issue(0, {10'd9, 10'd3}, 16'h0, 2'b11);
        // R10 idle row closes on budget
        repeat (40) @(negedge clk);
        check(ras_n, "R10", "row closed after budget", ras_n, 1);
        issue(0, {10'd9, 10'd3}, 16'h0, 2'b11);
        // R8/R10 page burst running into the budget
        for (int i = 0; i < 12; i++) issue(0, {10'd9, 10'(i)}, 16'h0, 2'b11);
        // R12 mixed traffic over three rows
        x = 32'h1357;
        for (int i = 0; i < 80; i++) begin
            logic [1:0] be;
            x = x * 32'd1103515245 + 32'd12345;
            be = x[5:4];
            if (be == 2'b00) be = 2'b11;
            issue(x[9], {rows[x[17:16] % 3], 7'd0, x[22:20]}, x[31:16], be);
        end
        repeat (40) @(negedge clk);
        check(rdq.size() == 0, "R12", "reads outstanding", rdq.size(), 0);
        check(opq.size() == 0, "R2", "accesses outstanding", opq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule